// File: doc/BRIEF.md
# Floating-Point Operand Unpack Unit

This block turns one 64-bit register value into the operand form used inside a floating-point datapath. A 3-bit format select says how to read the word: an IEEE single-precision value, an IEEE double-precision value, a 32-bit two's-complement integer or a 64-bit two's-complement integer. Float and integer inputs go through the same datapath. The result carries a sign, an unbiased signed exponent, a wide mantissa whose leading one sits at the top bit, a sticky bit, a class code and an invalid-operand flag.

Denormal floats and integers leave the decode stage with their leading one somewhere below the top bit. A leading-zero count and a left shift then move the leading one to the top bit and lower the exponent by the same amount. Signalling NaNs come out quieted but keep a class code of their own, and they raise the invalid flag. The output is registered: a strobed input appears one clock later, together with an output valid.

Top module: `fp_operand_unpack`

## Requirements
- R1: One clock edge after `in_valid` is sampled high, `out_valid` is high and every output field reflects that input. `out_valid` equals `in_valid` delayed by one clock. While `in_valid` is low, the result fields keep their last value.
- R2: Format codes: 0 selects single precision from bits 63:32. 1 selects double precision from bits 63:0. 2 selects a 32-bit integer from bits 31:0. 3 selects a 64-bit integer from bits 63:0. The sign output is the top bit of the selected field (bit 63 for codes 0, 1 and 3, bit 31 for code 2).
- R3: A float with biased exponent zero and fraction zero gives class zero (code 0) with exponent 0 and mantissa 0. The sign is kept.
- R4: A normal float gives class number (code 1). The implied one sits at mantissa bit MW-1, the fraction sits directly below it, and the exponent equals the biased exponent minus the bias (127 for single, 1023 for double).
- R5: A float with biased exponent zero and a nonzero fraction has no implied one. It gives class number with exponent 1-bias, then normalized. Example: the smallest double denormal gives exponent -1074 and mantissa bit MW-1 alone set.
- R6: A float with an all-ones exponent and a zero fraction gives class infinity (code 2), with exponent 0 and mantissa 0.
- R7: A float with an all-ones exponent and a nonzero fraction is a NaN. The fraction is placed unchanged with its MSB at mantissa bit MW-2, the exponent is 0, and the leading-one bit MW-1 is 0. If the fraction MSB is 1, the class is quiet NaN (code 3) and `out_invalid` is 0.
- R8: A NaN whose fraction MSB is 0 gives class signalling NaN (code 4). Mantissa bit MW-2 is set in the output and `out_invalid` is 1. In all other cases `out_invalid` is 0.
- R9: An integer equal to zero gives class zero with a clear sign. A nonzero integer gives class number: the mantissa is the magnitude with its leading one moved to bit MW-1, and the exponent is the bit position of that leading one.
- R10: The most negative integer of each width gives sign 1, exponent 31 (32-bit) or 63 (64-bit), and mantissa bit MW-1 alone set.
- R11: `out_sticky` is 0 for every input.
- R12: Format codes 4 to 7 give class zero with sign 0, exponent 0, mantissa 0, `out_invalid` 0 and `out_fmt_err` 1. Codes 0 to 3 give `out_fmt_err` 0.
- R13: Whenever the class is number, mantissa bit MW-1 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input strobe |
| in_fmt | input | 3 | Format select |
| in_word | input | 64 | Register value to unpack |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_sign | output | 1 | Sign |
| out_exp | output | EXP_W (13) | Unbiased exponent, two's complement |
| out_mant | output | MW (64) | Mantissa, leading one at bit MW-1 |
| out_sticky | output | 1 | Sticky bit, always cleared |
| out_class | output | 3 | 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| out_invalid | output | 1 | Invalid-operand flag, set for a signalling NaN |
| out_fmt_err | output | 1 | Unsupported format code |

## Verification
The bench builds the block with its default parameters: MW = 64 and EXP_W = 13. A 64-bit mantissa is exactly wide enough to hold the magnitude of the most negative 64-bit integer. A 13-bit exponent can hold both -1074, which the smallest double denormal reaches after a 52-place shift, and 1023, which the largest double normal gives. With these values the bench can check both ends of the normalizer shift range and both ends of the exponent range. Directed cases also cover every class code, each of the two float widths, and the lower-half placement of the 32-bit integer under nonzero upper-half bits.

// File: rtl/fpu_unpack_pkg.sv
package fpu_unpack_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } op_class_e;

    localparam logic [2:0] FMT_SGL = 3'd0;
    localparam logic [2:0] FMT_DBL = 3'd1;
    localparam logic [2:0] FMT_I32 = 3'd2;
    localparam logic [2:0] FMT_I64 = 3'd3;

    localparam int SGL_EW = 8;
    localparam int SGL_FW = 23;
    localparam int DBL_EW = 11;
    localparam int DBL_FW = 52;

endpackage

// File: rtl/unpack_lzc.sv
module unpack_lzc #(
    parameter int W  = 64,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    // the highest set bit wins because it is visited last
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/unpack_float.sv
module unpack_float
    import fpu_unpack_pkg::*;
#(
    parameter int EW    = 8,
    parameter int FW    = 23,
    parameter int MW    = 64,
    parameter int EXP_W = 13
) (
    input  logic [EW+FW-1:0] body,
    output logic [2:0]       cls,
    output logic [EXP_W-1:0] exp_o,
    output logic [MW-1:0]    mant_o,
    output logic             snan
);
    localparam int            BIAS = (1 << (EW - 1)) - 1;
    localparam logic [EW-1:0] EMAX = '1;

    logic [EW-1:0] bexp;
    logic [FW-1:0] frac;

    assign bexp = body[EW+FW-1:FW];
    assign frac = body[FW-1:0];

    always_comb begin
        cls    = CLS_ZERO;
        exp_o  = '0;
        mant_o = '0;
        snan   = 1'b0;
        if (bexp == '0) begin
            if (frac != '0) begin
                cls               = CLS_NUM;
                exp_o             = EXP_W'(1 - BIAS);
                mant_o[MW-2 -: FW] = frac;
            end
        end else if (bexp == EMAX) begin
            if (frac == '0) begin
                cls = CLS_INF;
            end else begin
                mant_o[MW-2 -: FW] = frac;
                if (frac[FW-1]) begin
                    cls = CLS_QNAN;
                end else begin
                    cls          = CLS_SNAN;
                    snan         = 1'b1;
                    mant_o[MW-2] = 1'b1;
                end
            end
        end else begin
            cls                = CLS_NUM;
            exp_o              = EXP_W'(int'(bexp) - BIAS);
            mant_o[MW-1]       = 1'b1;
            mant_o[MW-2 -: FW] = frac;
        end
    end
endmodule

// File: rtl/unpack_norm.sv
module unpack_norm #(
    parameter int MW    = 64,
    parameter int EXP_W = 13
) (
    input  logic             en,
    input  logic [EXP_W-1:0] exp_i,
    input  logic [MW-1:0]    mant_i,
    output logic [EXP_W-1:0] exp_o,
    output logic [MW-1:0]    mant_o
);
    localparam int CW = $clog2(MW + 1);

    logic [CW-1:0] lz;

    unpack_lzc #(.W(MW), .CW(CW)) u_lzc (
        .vec (mant_i),
        .cnt (lz)
    );

    always_comb begin
        exp_o  = exp_i;
        mant_o = mant_i;
        if (en) begin
            mant_o = mant_i << lz;
            exp_o  = exp_i - EXP_W'(lz);
        end
    end
endmodule

// File: rtl/fp_operand_unpack.sv
module fp_operand_unpack
    import fpu_unpack_pkg::*;
#(
    parameter int MW    = 64,
    parameter int EXP_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       in_fmt,
    input  logic [63:0]      in_word,
    output logic             out_valid,
    output logic             out_sign,
    output logic [EXP_W-1:0] out_exp,
    output logic [MW-1:0]    out_mant,
    output logic             out_sticky,
    output logic [2:0]       out_class,
    output logic             out_invalid,
    output logic             out_fmt_err
);
    localparam logic [EXP_W-1:0] INT_TOP = EXP_W'(MW - 1);

    logic [2:0]       s_cls, d_cls, pre_cls;
    logic [EXP_W-1:0] s_exp, d_exp, pre_exp, nrm_exp;
    logic [MW-1:0]    s_mant, d_mant, pre_mant, nrm_mant;
    logic             s_snan, d_snan, pre_inv, pre_sign, pre_err;
    logic [63:0]      int_sx, int_mag;

    unpack_float #(.EW(SGL_EW), .FW(SGL_FW), .MW(MW), .EXP_W(EXP_W)) u_sgl (
        .body   (in_word[62:32]),
        .cls    (s_cls),
        .exp_o  (s_exp),
        .mant_o (s_mant),
        .snan   (s_snan)
    );

    unpack_float #(.EW(DBL_EW), .FW(DBL_FW), .MW(MW), .EXP_W(EXP_W)) u_dbl (
        .body   (in_word[62:0]),
        .cls    (d_cls),
        .exp_o  (d_exp),
        .mant_o (d_mant),
        .snan   (d_snan)
    );

    // integer path: sign-extend, then two's-complement magnitude
    always_comb begin
        int_sx  = (in_fmt == FMT_I32) ? {{32{in_word[31]}}, in_word[31:0]} : in_word;
        int_mag = int_sx[63] ? (64'd0 - int_sx) : int_sx;
    end

    always_comb begin
        pre_sign = 1'b0;
        pre_cls  = CLS_ZERO;
        pre_exp  = '0;
        pre_mant = '0;
        pre_inv  = 1'b0;
        pre_err  = 1'b0;
        unique case (in_fmt)
            FMT_SGL: begin
                pre_sign = in_word[63];
                pre_cls  = s_cls;
                pre_exp  = s_exp;
                pre_mant = s_mant;
                pre_inv  = s_snan;
            end
            FMT_DBL: begin
                pre_sign = in_word[63];
                pre_cls  = d_cls;
                pre_exp  = d_exp;
                pre_mant = d_mant;
                pre_inv  = d_snan;
            end
            FMT_I32, FMT_I64: begin
                if (int_mag != 64'd0) begin
                    pre_sign = int_sx[63];
                    pre_cls  = CLS_NUM;
                    pre_exp  = INT_TOP;
                    pre_mant = MW'(int_mag);
                end
            end
            default: pre_err = 1'b1;
        endcase
    end

    unpack_norm #(.MW(MW), .EXP_W(EXP_W)) u_norm (
        .en     (pre_cls == CLS_NUM),
        .exp_i  (pre_exp),
        .mant_i (pre_mant),
        .exp_o  (nrm_exp),
        .mant_o (nrm_mant)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_sign    <= 1'b0;
            out_exp     <= '0;
            out_mant    <= '0;
            out_sticky  <= 1'b0;
            out_class   <= CLS_ZERO;
            out_invalid <= 1'b0;
            out_fmt_err <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sign    <= pre_sign;
                out_exp     <= nrm_exp;
                out_mant    <= nrm_mant;
                out_sticky  <= 1'b0;
                out_class   <= pre_cls;
                out_invalid <= pre_inv;
                out_fmt_err <= pre_err;
            end
        end
    end
endmodule

// File: rtl/fp_operand_unpack_chk.sv
module fp_operand_unpack_chk
    import fpu_unpack_pkg::*;
#(
    parameter int MW    = 64,
    parameter int EXP_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [2:0]       in_fmt,
    input logic             out_valid,
    input logic [MW-1:0]    out_mant,
    input logic             out_sticky,
    input logic [2:0]       out_class,
    input logic             out_invalid,
    input logic             out_fmt_err
);
    // R1
    valid_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_valid == $past(in_valid));

    // R1
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_mant) && $stable(out_class));

    // R8
    snan_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> out_class == CLS_SNAN);

    // R8
    snan_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_class == CLS_SNAN |-> out_invalid);

    // R7
    nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_class == CLS_QNAN || out_class == CLS_SNAN) |-> out_mant[MW-2] && !out_mant[MW-1]);

    // R13
    norm_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_class == CLS_NUM |-> out_mant[MW-1]);

    // R6
    empty_mant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_class == CLS_ZERO || out_class == CLS_INF) |-> out_mant == '0);

    // R12
    fmt_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fmt > 3'd3) |=> out_fmt_err && out_class == CLS_ZERO);

    // R11
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_sticky);
endmodule

bind fp_operand_unpack fp_operand_unpack_chk #(.MW(MW), .EXP_W(EXP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_fmt      (in_fmt),
    .out_valid   (out_valid),
    .out_mant    (out_mant),
    .out_sticky  (out_sticky),
    .out_class   (out_class),
    .out_invalid (out_invalid),
    .out_fmt_err (out_fmt_err)
);

// File: tb/sim_fp_operand_unpack.sv
module sim_fp_operand_unpack;
    localparam int CLK_PERIOD = 10;
    localparam int MW = 64;
    localparam int EXP_W = 13;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [2:0]       in_fmt = 3'd0;
    logic [63:0]      in_word = 64'd0;
    logic             out_valid, out_sign, out_sticky, out_invalid, out_fmt_err;
    logic [EXP_W-1:0] out_exp;
    logic [MW-1:0]    out_mant;
    logic [2:0]       out_class;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_operand_unpack #(.MW(MW), .EXP_W(EXP_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fmt(in_fmt), .in_word(in_word),
        .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp), .out_mant(out_mant),
        .out_sticky(out_sticky), .out_class(out_class), .out_invalid(out_invalid),
        .out_fmt_err(out_fmt_err)
    );

    localparam logic [63:0] TOP = 64'h8000_0000_0000_0000;

    task automatic apply(input logic [2:0] f, input logic [63:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_fmt   = f;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // compares every field, R11 (sticky clear) included
    task automatic expect_out(input string req, input logic s, input int e,
                              input logic [63:0] m, input logic [2:0] c,
                              input logic inv, input logic err);
        total++;
        if (out_valid !== 1'b1 || out_sign !== s || int'($signed(out_exp)) != e ||
            out_mant !== m || out_class !== c || out_invalid !== inv ||
            out_fmt_err !== err || out_sticky !== 1'b0) begin
            bad++;
            $display("FAIL %s: got v=%0b s=%0b e=%0d m=%h c=%0d inv=%0b err=%0b st=%0b exp v=1 s=%0b e=%0d m=%h c=%0d inv=%0b err=%0b st=0",
                     req, out_valid, out_sign, $signed(out_exp), out_mant, out_class,
                     out_invalid, out_fmt_err, out_sticky, s, e, m, c, inv, err);
        end
    endtask

    task automatic t_reset;
        total++;
        if (out_valid !== 1'b0 || out_class !== 3'd0 || out_mant !== 64'd0 || out_invalid !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset: got v=%0b c=%0d m=%h inv=%0b exp 0 0 0 0",
                     out_valid, out_class, out_mant, out_invalid);
        end
    endtask

    task automatic t_single;
        apply(3'd0, 64'h3F80_0000_0000_0000); expect_out("R4 sgl 1.0", 0, 0, TOP, 1, 0, 0);
        apply(3'd0, 64'hC020_0000_0000_0000); expect_out("R4 R2 sgl -2.5", 1, 1, 64'hA000_0000_0000_0000, 1, 0, 0);
        apply(3'd0, 64'h0000_0001_0000_0000); expect_out("R5 sgl denorm", 0, -149, TOP, 1, 0, 0);
        apply(3'd0, 64'h8000_0000_FFFF_FFFF); expect_out("R3 sgl -0", 1, 0, 64'd0, 0, 0, 0);
        apply(3'd0, 64'h7F80_0000_0000_0000); expect_out("R6 sgl inf", 0, 0, 64'd0, 2, 0, 0);
        apply(3'd0, 64'h7FC0_0000_0000_0000); expect_out("R7 sgl qnan", 0, 0, 64'h4000_0000_0000_0000, 3, 0, 0);
        apply(3'd0, 64'h7F80_0001_0000_0000); expect_out("R8 sgl snan", 0, 0, 64'h4000_0100_0000_0000, 4, 1, 0);
    endtask

    task automatic t_double;
        apply(3'd1, 64'h3FF0_0000_0000_0000); expect_out("R4 dbl 1.0", 0, 0, TOP, 1, 0, 0);
        apply(3'd1, 64'h7FEF_FFFF_FFFF_FFFF); expect_out("R4 dbl max", 0, 1023, 64'hFFFF_FFFF_FFFF_F800, 1, 0, 0);
        apply(3'd1, 64'h0000_0000_0000_0001); expect_out("R5 dbl denorm", 0, -1074, TOP, 1, 0, 0);
        apply(3'd1, 64'hFFF0_0000_0000_0001); expect_out("R8 dbl snan", 1, 0, 64'h4000_0000_0000_0800, 4, 1, 0);
        apply(3'd1, 64'hFFF0_0000_0000_0000); expect_out("R6 dbl -inf", 1, 0, 64'd0, 2, 0, 0);
    endtask

    task automatic t_int;
        apply(3'd2, 64'h0000_0000_FFFF_FFFF); expect_out("R9 R2 i32 -1", 1, 0, TOP, 1, 0, 0);
        apply(3'd2, 64'hFFFF_FFFF_0000_0006); expect_out("R9 R2 i32 6", 0, 2, 64'hC000_0000_0000_0000, 1, 0, 0);
        apply(3'd2, 64'hFFFF_FFFF_0000_0000); expect_out("R9 i32 zero", 0, 0, 64'd0, 0, 0, 0);
        apply(3'd2, 64'h0000_0000_8000_0000); expect_out("R10 i32 min", 1, 31, TOP, 1, 0, 0);
        apply(3'd3, 64'h8000_0000_0000_0000); expect_out("R10 i64 min", 1, 63, TOP, 1, 0, 0);
        apply(3'd3, 64'hFFFF_FFFF_FFFF_FFFD); expect_out("R9 i64 -3", 1, 1, 64'hC000_0000_0000_0000, 1, 0, 0);
        apply(3'd3, 64'h0000_0000_0000_0000); expect_out("R9 i64 zero", 0, 0, 64'd0, 0, 0, 0);
    endtask

    task automatic t_fmt;
        apply(3'd5, 64'hFFF0_0000_0000_0001); expect_out("R12 fmt 5", 0, 0, 64'd0, 0, 0, 1);
        apply(3'd7, 64'h3FF0_0000_0000_0000); expect_out("R12 fmt 7", 0, 0, 64'd0, 0, 0, 1);
    endtask

    task automatic t_hold;
        apply(3'd1, 64'h3FF0_0000_0000_0000);
        @(negedge clk);
        in_fmt  = 3'd3;
        in_word = 64'h0000_0000_0000_0003;
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || out_mant !== TOP || out_class !== 3'd1) begin
            bad++;
            $display("FAIL R1 hold: got v=%0b m=%h c=%0d exp v=0 m=%h c=1",
                     out_valid, out_mant, out_class, TOP);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_single();
        t_double();
        t_int();
        t_fmt();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule